// File: doc/BRIEF.md
# Noise Channel for a Three-Tone Sound Generator

This block makes the fourth voice of a small programmable sound generator: a noise source whose pitch is set by a shift-rate divider. A 16-bit linear-feedback shift register advances once for each rate event. It runs in one of two modes. In periodic mode it rotates a single bit, which gives a buzzy tone. In white mode it feeds back the XOR of two taps, which gives a hiss. The low bit of the register, scaled by a 4-bit attenuation, is the signed 9-bit sample that goes to the mixer.

The divider counts enable ticks, which arrive once every sixteen master-enable cycles. It can use one of three fixed periods, or it can follow the 10-bit period of the third tone channel, so that the noise pitch tracks a melodic voice. When the noise control register is written, the decoder sends a one-cycle clear pulse. That pulse reseeds the shift register and restarts the divider. Register decoding and mixing are handled outside this block.

Top module: `psg_noise_chan`

## Requirements
- R1: After reset the shift register holds 16'h8000, the divider count is zero, and the sample is 0.
- R2: With mode[1:0]=00 the register shifts on every 16th enable tick. Counting from a clear, in periodic mode the first nonzero sample appears after tick 240.
- R3: With mode[1:0]=01 a shift happens every 32 ticks, and with 10 it happens every 64 ticks.
- R4: With mode[1:0]=11 a shift happens every N ticks, where N is the tone period input. A period of 0 shifts on every tick.
- R5: The register changes only on a clock where the tick input is high and the divider reaches its limit, or on a clear. It shifts once per such event.
- R6: With mode[2]=1 (white), one shift moves the register right by one and puts bit0 XOR bit3 into bit 15.
- R7: With mode[2]=0 (periodic), one shift rotates the register right by one, so bit 0 moves to bit 15.
- R8: A clear pulse sets the register to 16'h8000 and the divider count to zero on the next edge. A clear takes priority over a tick.
- R9: The sample is 0 when register bit 0 is 0. Otherwise it is the positive level given by the attenuation: 255,203,161,128,101,80,64,51,40,32,25,20,16,13,10 for codes 0 to 14, and 0 for code 15.
- R10: The register never holds all zeros. A zero next state is replaced by 16'h8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Enable pulse, once per 16 master enables |
| mode | input | 3 | [1:0] rate select, [2] white (1) or periodic (0) |
| tone_period | input | 10 | Period of the third tone channel, in ticks |
| clr | input | 1 | One-cycle reseed pulse on a control write |
| atten | input | 4 | Attenuation, 0 loudest, 15 silent |
| sample | output | 9 | Signed output sample |

## Verification
On every clock, the assertions check four things: the register holds between rate events, the register is reseeded after a clear, it is never all zeros, and the sample is silent whenever the low bit is zero or the attenuation is 15. They also check that a periodic-mode shift is an exact rotation. Only the bench scenarios can show that each rate selection gives the right number of ticks between shifts, that the tone-period mode (including period 0) follows its input, and that the white-noise sequence and the attenuation levels match over long random runs.

// File: rtl/psg_noise_chan.sv
module psg_noise_chan #(
  parameter int LFSR_W = 16,
  parameter int PER_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [2:0]       mode,
  input  logic [PER_W-1:0] tone_period,
  input  logic             clr,
  input  logic [3:0]       atten,
  output logic [8:0]       sample
);
  localparam logic [LFSR_W-1:0] SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  logic [LFSR_W-1:0] lfsr;
  logic [PER_W-1:0]  cnt, limit;
  logic              fb, step;
  logic [LFSR_W-1:0] nxt;
  logic [7:0]        amp;

  always_comb begin
    case (mode[1:0])
      2'b00:   limit = PER_W'(15);
      2'b01:   limit = PER_W'(31);
      2'b10:   limit = PER_W'(63);
      default: limit = (tone_period == '0) ? '0 : tone_period - 1'b1;
    endcase
  end

  assign step = tick && (cnt >= limit);
  assign fb   = mode[2] ? (lfsr[0] ^ lfsr[3]) : lfsr[0];
  assign nxt  = {fb, lfsr[LFSR_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lfsr <= SEED;
      cnt  <= '0;
    end else if (tick) begin
      if (step) begin
        cnt  <= '0;
        lfsr <= (nxt == '0) ? SEED : nxt;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (atten)
      4'd0:  amp = 8'd255;
      4'd1:  amp = 8'd203;
      4'd2:  amp = 8'd161;
      4'd3:  amp = 8'd128;
      4'd4:  amp = 8'd101;
      4'd5:  amp = 8'd80;
      4'd6:  amp = 8'd64;
      4'd7:  amp = 8'd51;
      4'd8:  amp = 8'd40;
      4'd9:  amp = 8'd32;
      4'd10: amp = 8'd25;
      4'd11: amp = 8'd20;
      4'd12: amp = 8'd16;
      4'd13: amp = 8'd13;
      4'd14: amp = 8'd10;
      default: amp = 8'd0;
    endcase
  end

  assign sample = lfsr[0] ? {1'b0, amp} : 9'd0;

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> $stable(lfsr));

  p_reseed_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (lfsr == SEED && cnt == '0));

  p_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

  p_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (!lfsr[0] || atten == 4'd15) |-> sample == 9'd0);

  p_rotate_r7: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !mode[2]) |=> lfsr == {$past(lfsr[0]), $past(lfsr[LFSR_W-1:1])});
endmodule

// File: tb/psg_noise_chan_bench.sv
module psg_noise_chan_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [2:0] mode = 3'b100;
  logic [9:0] tone_period = 10'd0;
  logic       clr = 1'b0;
  logic [3:0] atten = 4'd15;
  logic [8:0] sample;

  int vecs = 0;
  int bad = 0;
  int cyc = 0;
  string tag = "R1";

  logic [15:0] m_lfsr;
  logic [9:0]  m_cnt;

  always #4 clk = ~clk;

  psg_noise_chan u_psg_noise_chan (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode),
    .tone_period(tone_period), .clr(clr), .atten(atten), .sample(sample)
  );

  function automatic logic [7:0] level(input logic [3:0] a);
    logic [7:0] t [16] = '{8'd255, 8'd203, 8'd161, 8'd128, 8'd101, 8'd80, 8'd64, 8'd51,
                           8'd40, 8'd32, 8'd25, 8'd20, 8'd16, 8'd13, 8'd10, 8'd0};
    return t[a];
  endfunction

  function automatic logic [9:0] lim_of(input logic [2:0] m, input logic [9:0] tp);
    case (m[1:0])
      2'b00: return 10'd15;
      2'b01: return 10'd31;
      2'b10: return 10'd63;
      default: return (tp == 10'd0) ? 10'd0 : tp - 10'd1;
    endcase
  endfunction

  function automatic logic [15:0] shift_of(input logic [15:0] s, input logic white);
    logic [15:0] n;
    n = {white ? (s[0] ^ s[3]) : s[0], s[15:1]};
    return (n == 16'd0) ? 16'h8000 : n;
  endfunction

  always @(posedge clk) begin
    if (rst || clr) begin
      m_lfsr <= 16'h8000;
      m_cnt  <= 10'd0;
    end else if (tick) begin
      if (m_cnt >= lim_of(mode, tone_period)) begin
        m_cnt  <= 10'd0;
        m_lfsr <= shift_of(m_lfsr, mode[2]);
      end else begin
        m_cnt <= m_cnt + 10'd1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected under 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(tag, int'(sample), m_lfsr[0] ? int'(level(atten)) : 0);
  endtask

  task automatic first_hit(input string t, input logic [2:0] m, input logic [9:0] tp, input int exp);
    @(negedge clk);
    mode = m; tone_period = tp; atten = 4'd0; tick = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; tick = 1'b1;
    for (int i = 1; i <= 1000; i++) begin
      @(negedge clk);
      if (sample != 9'd0) begin
        chk(t, i, exp);
        tick = 1'b0;
        return;
      end
    end
    chk(t, 1001, exp);
    tick = 1'b0;
  endtask

  task automatic rand_run(input string t, input logic [2:0] m, input int n, input int tick_mod);
    tag = t;
    mode = m;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model();
      tick = ($urandom % tick_mod) == 0;
      if ($urandom % 64 == 0) atten = 4'($urandom);
      clr = ($urandom % 500) == 0;
      if (m[1:0] == 2'b11 && $urandom % 300 == 0) tone_period = 10'($urandom % 8);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(sample), 0);
    atten = 4'd0;
    @(negedge clk);
    chk("R1", int'(sample), 0);

    first_hit("R2", 3'b000, 10'd0, 240);
    first_hit("R3", 3'b001, 10'd0, 480);
    first_hit("R3", 3'b010, 10'd0, 960);
    first_hit("R4", 3'b011, 10'd3, 45);
    first_hit("R4", 3'b011, 10'd0, 15);
    first_hit("R7", 3'b011, 10'd1, 15);

    @(negedge clk);
    mode = 3'b000; tick = 1'b1; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; tick = 1'b0;
    chk("R8", int'(sample), 0);

    tone_period = 10'd2;
    rand_run("R2", 3'b000, 6000, 1);
    rand_run("R6", 3'b100, 12000, 1);
    rand_run("R3", 3'b101, 12000, 2);
    rand_run("R3", 3'b110, 12000, 1);
    rand_run("R4", 3'b111, 12000, 3);
    rand_run("R7", 3'b011, 8000, 1);
    rand_run("R5", 3'b100, 12000, 16);
    rand_run("R10", 3'b111, 12000, 1);

    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      tick = 1'b0; clr = 1'b0; atten = 4'(a);
      @(negedge clk);
      chk("R9", int'(sample), m_lfsr[0] ? int'(level(4'(a))) : 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule